// File: doc/BRIEF.md
# Core-Local Timer Unit

This block gives a processor core its local sense of time. A 64-bit time base counts up by one on every cycle where the tick enable is high. A 32-bit down-counter runs from the same tick and can reload itself from a shadow register when it runs out. Two periodic event sources watch one selectable bit of the time base each. One is an interval timer and the other is a first-stage watchdog.

Software programs the unit through a small word-wide register port. It sets enables and period selections in a control register and reads the recorded events back from a status register. Status bits are cleared by writing ones to them. Three level interrupt lines are driven from the status bits, each gated by its enable: one for the decrementer, one for the interval timer and one for the watchdog.

Top module: `core_timer_unit`

## Requirements
- R1: After reset, every register reads zero (time base, decrementer, reload, control, status) and all three interrupt outputs are low.
- R2: Register addresses: 0 = time base upper word, 1 = time base lower word, 2 = decrementer, 3 = reload value, 4 = control, 5 = status; addresses 6 and 7 read zero. A read returns the current value combinationally. A write to addresses 0 to 4 loads the written word, and the control register keeps all 32 bits. A write to the decrementer takes priority over a tick in the same cycle.
- R3: The time base increments by one on each tick, with carry from the lower word into the upper word. A write to either time base word replaces the tick in that cycle.
- R4: A write to status clears exactly the bits written as one and leaves the rest. An event that sets a bit in the same cycle wins over the clear.
- R5: On a tick, a non-zero decrementer counts down by one. The step from 1 to 0 is the expiry and sets status bit 27. A decrementer at zero stays at zero and produces no event.
- R6: With control bit 22 set, an expiry loads the reload value (the value held before any same-cycle reload write) instead of zero.
- R7: The interval timer watches time-base bit 63 - {control[16:13], control[25:24]}. A tick that moves that bit from 0 to 1 sets status bit 26.
- R8: The watchdog watches time-base bit 63 - {control[20:17], control[31:30]}. When that bit rises, status bit 31 is set if it was clear; otherwise status bit 30 is set.
- R9: decIrq = status[27] AND control[26]; fitIrq = status[26] AND control[23]; wdtIrq = status[30] AND control[27]. All three are levels that follow the register state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Time base / decrementer advance enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| decIrq | output | 1 | Decrementer interrupt level |
| fitIrq | output | 1 | Interval timer interrupt level |
| wdtIrq | output | 1 | Watchdog interrupt level |

## Verification
The bound checker watches, on every cycle, that the time base steps by exactly one per plain tick and that the decrementer holds at zero. It also checks that an expiry sets the decrementer status bit, that a reload lands the shadow value, that write-one clears take effect, and that the watchdog interrupt status only follows an armed enable-next bit. Only the bench scenarios show the end-to-end behaviour. This covers the exact bit index picked by the split period fields, the repeat period of each event, the priority of a set over a same-cycle clear, and the register read map, all compared against a behavioural model on every clock.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int DATA_W = 32;
  localparam int TB_W   = 2 * DATA_W;
  localparam int ADDR_W = 3;
  localparam int IDX_W  = $clog2(TB_W);

  localparam logic [ADDR_W-1:0] A_TB_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_TB_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_DEC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STS   = 3'd5;

  // control bit positions
  localparam int C_WPER_LO = 30;
  localparam int C_WIE     = 27;
  localparam int C_DIE     = 26;
  localparam int C_FPER_LO = 24;
  localparam int C_FIE     = 23;
  localparam int C_ARL     = 22;
  localparam int C_WEXT_LO = 17;
  localparam int C_FEXT_LO = 13;

  // status bit positions
  localparam int S_ENW = 31;
  localparam int S_WIS = 30;
  localparam int S_DIS = 27;
  localparam int S_FIS = 26;

  typedef struct packed {
    logic             tbHiWr;
    logic             tbLoWr;
    logic             decWr;
    logic             rldWr;
    logic             autoReload;
    logic [IDX_W-1:0] fitIdx;
    logic [IDX_W-1:0] wdtIdx;
  } dpStrobe_t;

  typedef struct packed {
    logic decExp;
    logic fitHit;
    logic wdtHit;
  } dpEvent_t;

  function automatic logic [IDX_W-1:0] selIndex(input logic [3:0] ext, input logic [1:0] per);
    return IDX_W'(TB_W - 1) - {ext, per};
  endfunction
endpackage

// File: rtl/ctu_datapath.sv
module ctu_datapath
  import ctu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [TB_W-1:0]   tbVal,
  output logic [DATA_W-1:0] decVal,
  output logic [DATA_W-1:0] rldVal,
  output dpEvent_t          evt
);
  logic [TB_W-1:0] tbInc;
  logic [1:0]      bitHit;
  logic [IDX_W-1:0] watchIdx [2];

  assign tbInc       = tbVal + TB_W'(1);
  assign watchIdx[0] = strobe.fitIdx;
  assign watchIdx[1] = strobe.wdtIdx;

  for (genvar g = 0; g < 2; g++) begin : g_bitwatch
    assign bitHit[g] = tickEn & ~tbVal[watchIdx[g]] & tbInc[watchIdx[g]];
  end

  assign evt.fitHit = bitHit[0];
  assign evt.wdtHit = bitHit[1];
  assign evt.decExp = tickEn & ~strobe.decWr & (decVal == DATA_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbVal  <= '0;
      decVal <= '0;
      rldVal <= '0;
    end else begin
      if (strobe.tbHiWr || strobe.tbLoWr) begin
        if (strobe.tbHiWr) tbVal[TB_W-1:DATA_W] <= wrData;
        if (strobe.tbLoWr) tbVal[DATA_W-1:0]    <= wrData;
      end else if (tickEn) begin
        tbVal <= tbInc;
      end

      if (strobe.decWr) begin
        decVal <= wrData;
      end else if (tickEn && decVal != '0) begin
        decVal <= (evt.decExp && strobe.autoReload) ? rldVal : decVal - DATA_W'(1);
      end

      if (strobe.rldWr) rldVal <= wrData;
    end
  end
endmodule

// File: rtl/ctu_ctrl.sv
module ctu_ctrl
  import ctu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  dpEvent_t          evt,
  input  logic [TB_W-1:0]   tbVal,
  input  logic [DATA_W-1:0] decVal,
  input  logic [DATA_W-1:0] rldVal,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctlVal,
  output logic [DATA_W-1:0] stsVal,
  output logic [DATA_W-1:0] rdData,
  output logic              decIrq,
  output logic              fitIrq,
  output logic              wdtIrq
);
  logic [DATA_W-1:0] setMask;
  logic [DATA_W-1:0] clrMask;

  assign strobe.tbHiWr     = wrEn && addr == A_TB_HI;
  assign strobe.tbLoWr     = wrEn && addr == A_TB_LO;
  assign strobe.decWr      = wrEn && addr == A_DEC;
  assign strobe.rldWr      = wrEn && addr == A_RLD;
  assign strobe.autoReload = ctlVal[C_ARL];
  assign strobe.fitIdx     = selIndex(ctlVal[C_FEXT_LO +: 4], ctlVal[C_FPER_LO +: 2]);
  assign strobe.wdtIdx     = selIndex(ctlVal[C_WEXT_LO +: 4], ctlVal[C_WPER_LO +: 2]);

  assign clrMask = (wrEn && addr == A_STS) ? wrData : '0;

  always_comb begin
    setMask        = '0;
    setMask[S_DIS] = evt.decExp;
    setMask[S_FIS] = evt.fitHit;
    if (evt.wdtHit) begin
      if (stsVal[S_ENW]) setMask[S_WIS] = 1'b1;
      else               setMask[S_ENW] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlVal <= '0;
      stsVal <= '0;
    end else begin
      if (wrEn && addr == A_CTL) ctlVal <= wrData;
      stsVal <= (stsVal & ~clrMask) | setMask;
    end
  end

  always_comb begin
    case (addr)
      A_TB_HI: rdData = tbVal[TB_W-1:DATA_W];
      A_TB_LO: rdData = tbVal[DATA_W-1:0];
      A_DEC:   rdData = decVal;
      A_RLD:   rdData = rldVal;
      A_CTL:   rdData = ctlVal;
      A_STS:   rdData = stsVal;
      default: rdData = '0;
    endcase
  end

  assign decIrq = stsVal[S_DIS] & ctlVal[C_DIE];
  assign fitIrq = stsVal[S_FIS] & ctlVal[C_FIE];
  assign wdtIrq = stsVal[S_WIS] & ctlVal[C_WIE];
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
  import ctu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              decIrq,
  output logic              fitIrq,
  output logic              wdtIrq
);
  dpStrobe_t         strobe;
  dpEvent_t          evt;
  logic [TB_W-1:0]   tbVal;
  logic [DATA_W-1:0] decVal;
  logic [DATA_W-1:0] rldVal;
  logic [DATA_W-1:0] ctlVal;
  logic [DATA_W-1:0] stsVal;

  ctu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .evt(evt), .tbVal(tbVal), .decVal(decVal), .rldVal(rldVal),
    .strobe(strobe), .ctlVal(ctlVal), .stsVal(stsVal), .rdData(regRdData),
    .decIrq(decIrq), .fitIrq(fitIrq), .wdtIrq(wdtIrq)
  );

  ctu_datapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe), .wrData(regWrData),
    .tbVal(tbVal), .decVal(decVal), .rldVal(rldVal), .evt(evt)
  );
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker
  import ctu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [TB_W-1:0]   tbVal,
  input logic [DATA_W-1:0] decVal,
  input logic [DATA_W-1:0] rldVal,
  input logic [DATA_W-1:0] stsVal,
  input logic              decIrq,
  input logic [DATA_W-1:0] ctlVal
);
  logic tbWr, decWr, rldWr, stsWr;
  assign tbWr  = wrEn && (addr == A_TB_HI || addr == A_TB_LO);
  assign decWr = wrEn && addr == A_DEC;
  assign rldWr = wrEn && addr == A_RLD;
  assign stsWr = wrEn && addr == A_STS;

  p_tb_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !tbWr) |=> tbVal == $past(tbVal) + TB_W'(1));

  p_dec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decVal == '0 && !decWr) |=> decVal == '0);

  p_dec_expire_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decVal == DATA_W'(1) && tickEn && !decWr) |=> stsVal[S_DIS]);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decVal == DATA_W'(1) && tickEn && !decWr && ctlVal[C_ARL] && !rldWr) |=> decVal == rldVal);

  p_w1c_fit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && wrData[S_FIS] && !tickEn) |=> !stsVal[S_FIS]);

  p_wis_after_enw_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsVal[S_WIS]) |-> $past(stsVal[S_ENW]));

  p_dec_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decIrq) |-> (ctlVal[C_DIE] && stsVal[S_DIS]));
endmodule

bind core_timer_unit ctu_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(regWrEn), .addr(regAddr),
  .wrData(regWrData), .tbVal(tbVal), .decVal(decVal), .rldVal(rldVal),
  .stsVal(stsVal), .decIrq(decIrq), .ctlVal(ctlVal)
);

// File: tb/tb_core_timer_unit.sv
module tb_core_timer_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        decIrq, fitIrq, wdtIrq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [63:0] mTb = '0;
  logic [31:0] mDec = '0, mRld = '0, mCtl = '0, mSts = '0;

  always #10 clk = ~clk;

  core_timer_unit dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .decIrq(decIrq), .fitIrq(fitIrq), .wdtIrq(wdtIrq)
  );

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mTb[63:32];
      3'd1: return mTb[31:0];
      3'd2: return mDec;
      3'd3: return mRld;
      3'd4: return mCtl;
      3'd5: return mSts;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare(input string req);
    logic [2:0] expIrq;
    expIrq = {mSts[27] & mCtl[26], mSts[26] & mCtl[23], mSts[30] & mCtl[27]};
    checks++;
    if (regRdData !== mRead(regAddr)) begin
      errors++;
      $display("FAIL %s read addr=%0d actual=%h expected=%h", req, regAddr, regRdData, mRead(regAddr));
    end
    checks++;
    if ({decIrq, fitIrq, wdtIrq} !== expIrq) begin
      errors++;
      $display("FAIL %s R9 irq {dec,fit,wdt} actual=%b expected=%b", req, {decIrq, fitIrq, wdtIrq}, expIrq);
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d, input bit tk, input string req);
    logic [63:0] tbN;
    logic [31:0] setv, nDec;
    int fi, wi;
    bit fitE, wdtE, decE, decW;
    regWrEn = we; regAddr = a; regWrData = d; tickEn = tk;
    tbN  = mTb + 64'd1;
    fi   = 63 - int'({mCtl[16:13], mCtl[25:24]});
    wi   = 63 - int'({mCtl[20:17], mCtl[31:30]});
    fitE = tk && !mTb[fi] && tbN[fi];
    wdtE = tk && !mTb[wi] && tbN[wi];
    decW = we && a == 3'd2;
    decE = tk && !decW && mDec == 32'd1;
    setv = '0;
    if (decE) setv[27] = 1'b1;
    if (fitE) setv[26] = 1'b1;
    if (wdtE) begin
      if (mSts[31]) setv[30] = 1'b1; else setv[31] = 1'b1;
    end
    nDec = mDec;
    if (decW) nDec = d;
    else if (tk && mDec != 0) nDec = (decE && mCtl[22]) ? mRld : mDec - 32'd1;
    mSts = (mSts & ~((we && a == 3'd5) ? d : 32'h0)) | setv;
    if (we && (a == 3'd0 || a == 3'd1)) begin
      if (a == 3'd0) mTb[63:32] = d; else mTb[31:0] = d;
    end else if (tk) mTb = tbN;
    if (we && a == 3'd4) mCtl = d;
    if (we && a == 3'd3) mRld = d;
    mDec = nDec;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare(req);
  endtask

  task automatic idle(input int n, input bit tk, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 3'(cyc % 6), 32'h0, tk, req);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    step(1'b1, a, d, 1'b0, req);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    idle(8, 1'b0, "R1 reset values");

    // R2: register map and loads
    wr(3'd0, 32'h1234_5678, "R2 tb hi");
    wr(3'd1, 32'hFFFF_FFFD, "R2 tb lo");
    wr(3'd3, 32'h0000_00A5, "R2 reload");
    wr(3'd4, 32'h3000_0000, "R2 control all bits");
    wr(3'd2, 32'd5, "R2 dec");
    idle(6, 1'b0, "R2 readback");
    step(1'b1, 3'd2, 32'd9, 1'b1, "R2 dec write beats tick");
    wr(3'd2, 32'd5, "R2 dec");

    // R3 carry and R5 countdown/stop
    idle(10, 1'b1, "R3 R5 tick carry and dec stop");
    step(1'b1, 3'd1, 32'h0000_0010, 1'b1, "R3 tb write replaces tick");
    idle(6, 1'b1, "R5 dec held at zero");

    // R9 enable decrementer irq, R4 clear
    wr(3'd4, 32'h0400_0000, "R9 dec irq enable");
    wr(3'd5, 32'h0000_0000, "R4 zero write keeps");
    wr(3'd5, 32'h0800_0000, "R4 clear dec status");

    // R6 auto reload
    wr(3'd3, 32'd3, "R6 reload");
    wr(3'd4, 32'h0440_0000, "R6 enable");
    wr(3'd2, 32'd2, "R6 dec");
    idle(14, 1'b1, "R6 periodic reload");
    wr(3'd4, 32'h0000_0000, "R6 disable");
    wr(3'd5, 32'hFFFF_FFFF, "R4 clear all");

    // R7 interval timer, index 0 then index 3
    wr(3'd4, 32'h0381_E000, "R7 idx0");
    idle(6, 1'b1, "R7 idx0 events");
    for (int i = 0; i < 6; i++) step(1'b1, 3'd5, 32'h0400_0000, 1'b1, "R4 set beats clear");
    wr(3'd5, 32'h0400_0000, "R4 clear fit");
    wr(3'd4, 32'h0081_E000, "R7 idx3");
    for (int i = 0; i < 40; i++) begin
      if (i % 10 == 9) step(1'b1, 3'd5, 32'h0400_0000, 1'b1, "R7 idx3 clear");
      else step(1'b0, 3'd5, 32'h0, 1'b1, "R7 idx3 period");
    end

    // R8 watchdog, index 1
    wr(3'd5, 32'hFFFF_FFFF, "R4 clear all");
    wr(3'd4, 32'h881E_0000, "R8 idx1");
    for (int i = 0; i < 12; i++) step(1'b0, 3'd5, 32'h0, 1'b1, "R8 enw then wis");
    wr(3'd5, 32'hF000_0000, "R8 clear watchdog state");
    for (int i = 0; i < 6; i++) step(1'b0, 3'd5, 32'h0, 1'b1, "R8 rearm");

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      bit we;
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 8);
      d  = $urandom;
      if (we && a == 3'd4) d = d | 32'h0001_E000;
      if (we && a == 3'd2) d = d % 20;
      if (we && a == 3'd3) d = d % 12;
      step(we, a, d, ($urandom % 3) != 0, "R2 R4 R5 R6 R7 R8 mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule